// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a byte-wide register file inside the chip. It watches the two bus lines with a fast system clock, recognises bus conditions, checks its own 7-bit device address, takes one sub-address byte that loads a register pointer, and then moves data bytes in either direction with acknowledges. SDA is driven open-drain: the block only ever pulls the line low through `sda_oe`, and a pull-up or the pad logic supplies the high level.

The register file is reached through a simple port. The block presents the pointer on `reg_addr` and issues a one-cycle `reg_we` with `reg_wdata` for every received data byte. For reads it issues a one-cycle `reg_rd` and captures `reg_rdata`, which is combinational from `reg_addr`, in that same cycle. Whether the pointer advances after each data byte is decided by the level of `inc_en`, which comes from outside the block.

Top module: `i2c_regport_slave`

## Requirements
- R1: The device address is 0011101b when `strap_sel` is 1 and 0011110b when it is 0. A matching address byte is acknowledged. For any other address the block never pulls SDA low for the rest of that transfer, and it issues no register strobe.
- R2: START (SDA falls while SCL is high) in any state restarts address reception. STOP (SDA rises while SCL is high) returns the block to idle. A data byte cut short by STOP is not written.
- R3: Bytes are taken and sent most significant bit first. The eighth bit of the address byte selects the direction: 1 is read and 0 is write.
- R4: The byte after an acknowledged write address is the sub-address. Its low 7 bits load the register pointer and its bit 7 is ignored. The block acknowledges this byte.
- R5: Every received data byte is acknowledged and produces exactly one `reg_we` pulse, while SCL is low, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: When `inc_en` is 1 the pointer advances by one after each data byte, wrapping from 7Fh to 00h. When `inc_en` is 0 the pointer stays fixed.
- R7: After a write address and sub-address, a repeated START and the address with R/W set to 1 make the block return bytes from the pointer, in order.
- R8: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte. A not-acknowledge ends the read with no further register access.
- R9: `reg_rd` fires exactly once for each byte that is sent. It fires while SCL is low, before the first bit of that byte appears on SDA.
- R10: The block starts pulling SDA low only while SCL is low.
- R11: After reset SDA is released and neither register strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_sel | input | 1 | Address strap; selects the two low address bits |
| inc_en | input | 1 | 1 advances the pointer after each data byte |
| reg_addr | output | REG_AW | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
The hardest situations to reach are the bus conditions that arrive in the middle of a byte. Examples are a STOP after four data bits, and a repeated START while the sub-address is still being shifted in. These can be produced only by driving SCL and SDA bit by bit, not whole bytes at a time. The bench therefore builds every transfer from single-bit tasks and can cut any byte short. It also forces the pointer to wrap by writing across 7Fh, and it keeps checking that SDA stays released through transfers sent to the wrong address.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
   localparam int BYTE_W = 8;
   localparam int DEV_W  = 7;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_DEV,
      PH_DEV_ACK,
      PH_SUB,
      PH_SUB_ACK,
      PH_WR,
      PH_WR_ACK,
      PH_RD,
      PH_RD_ACK
   } phase_e;

   // Full device address: fixed upper part, strap picks the low pair.
   function automatic logic [DEV_W-1:0] dev_id(input logic [4:0] hi, input logic strap);
      return {hi, (strap ? 2'b01 : 2'b10)};
   endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [1:0] raw, cur, last;

   assign raw = {scl_i, sda_i};

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign cur[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 2'b11;
      else        last <= cur;
   end

   assign sda_s     = cur[0];
   assign scl_rise  =  cur[1] & ~last[1];
   assign scl_fall  = ~cur[1] &  last[1];
   assign start_det =  cur[1] &  last[1] &  last[0] & ~cur[0];
   assign stop_det  =  cur[1] &  last[1] & ~last[0] &  cur[0];
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
   import i2c_regport_pkg::*;
#(
   parameter int          REG_AW  = 7,
   parameter logic [4:0]  ADDR_HI = 5'b00111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              strap_sel,
   input  logic              inc_en,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic [REG_AW-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_rd,
   output logic              sda_oe
);
   localparam int                CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0]  LAST_B = CNT_W'(BYTE_W);

   phase_e            ph;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic [REG_AW-1:0] ptr;
   logic              rw, mack;
   logic              rx_ph, byte_end;

   assign rx_ph    = (ph == PH_DEV) || (ph == PH_SUB) || (ph == PH_WR);
   assign byte_end = scl_fall && (cnt == LAST_B);

   always_comb begin
      reg_addr  = ptr;
      reg_wdata = sh;
      reg_we    = (ph == PH_WR) && byte_end;
      reg_rd    = scl_fall && (((ph == PH_DEV_ACK) && rw) || ((ph == PH_RD_ACK) && mack));
      sda_oe    = (ph == PH_DEV_ACK) || (ph == PH_SUB_ACK) || (ph == PH_WR_ACK)
                  || ((ph == PH_RD) && !sh[BYTE_W-1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         cnt  <= '0;
         sh   <= '0;
         ptr  <= '0;
         rw   <= 1'b0;
         mack <= 1'b0;
      end else if (start_det) begin
         ph  <= PH_DEV;
         cnt <= '0;
      end else if (stop_det) begin
         ph <= PH_IDLE;
      end else if (rx_ph) begin
         if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
         end else if (byte_end) begin
            unique case (ph)
               PH_DEV: begin
                  if (sh[BYTE_W-1:1] == dev_id(ADDR_HI, strap_sel)) begin
                     ph <= PH_DEV_ACK;
                     rw <= sh[0];
                  end else begin
                     ph <= PH_IDLE;
                  end
               end
               PH_SUB: begin
                  ptr <= sh[REG_AW-1:0];
                  ph  <= PH_SUB_ACK;
               end
               default: begin
                  if (inc_en) ptr <= ptr + 1'b1;
                  ph <= PH_WR_ACK;
               end
            endcase
         end
      end else begin
         unique case (ph)
            PH_DEV_ACK: if (scl_fall) begin
               cnt <= '0;
               if (rw) begin
                  sh <= reg_rdata;
                  ph <= PH_RD;
               end else begin
                  ph <= PH_SUB;
               end
            end
            PH_SUB_ACK, PH_WR_ACK: if (scl_fall) begin
               cnt <= '0;
               ph  <= PH_WR;
            end
            PH_RD: begin
               if (scl_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (byte_end) begin
                  ph <= PH_RD_ACK;
                  if (inc_en) ptr <= ptr + 1'b1;
               end else if (scl_fall) begin
                  sh <= {sh[BYTE_W-2:0], 1'b0};
               end
            end
            PH_RD_ACK: begin
               if (scl_rise) begin
                  mack <= !sda_s;
               end else if (scl_fall) begin
                  if (mack) begin
                     sh  <= reg_rdata;
                     cnt <= '0;
                     ph  <= PH_RD;
                  end else begin
                     ph <= PH_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
   import i2c_regport_pkg::*;
#(
   parameter int         REG_AW      = 7,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_HI     = 5'b00111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              strap_sel,
   input  logic              inc_en,
   output logic [REG_AW-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_rd,
   input  logic [BYTE_W-1:0] reg_rdata
);
   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   if (REG_AW < 1 || REG_AW > BYTE_W - 1) begin : g_bad_aw
      $error("i2c_regport_slave: REG_AW must be 1..7");
   end

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_xfer_ctrl #(.REG_AW(REG_AW), .ADDR_HI(ADDR_HI)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap_sel (strap_sel),
      .inc_en    (inc_en),
      .reg_rdata (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rd    (reg_rd),
      .sda_oe    (sda_oe)
   );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic reg_we,
   input logic reg_rd
);
   a_r10_pull_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   a_r5_we_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !scl_i);

   a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   a_r9_rd_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> !scl_i);
endmodule

bind i2c_regport_slave i2c_regport_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_i  (scl_i),
   .sda_oe (sda_oe),
   .reg_we (reg_we),
   .reg_rd (reg_rd)
);

// File: tb/tb_i2c_regport_slave.sv
module tb_i2c_regport_slave;
   localparam int H = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       strap = 1'b1, inc = 1'b1;
   logic       sda_oe, reg_we, reg_rd;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   wire        sda_line = sda_m & ~sda_oe;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [7:0] rf     [128];
   logic [7:0] shadow [128];
   logic [7:0] wbuf   [4];
   logic [6:0] exp_wa [$];
   logic [7:0] exp_wd [$];
   logic [6:0] exp_ra [$];
   logic       oe_prev = 1'b0;

   always #10 clk = ~clk;

   i2c_regport_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_sel(strap), .inc_en(inc), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = rf[reg_addr];
   always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Per-clock reference comparison of strobes and SDA drive.
   always @(negedge clk) if (rst_n && !done) begin
      if (reg_we) begin
         if (exp_wa.size() == 0) chk(0, "R5 unexpected write", int'(reg_addr), 0);
         else begin
            logic [6:0] a; logic [7:0] d;
            a = exp_wa.pop_front(); d = exp_wd.pop_front();
            chk(reg_addr == a && reg_wdata == d, "R5 write strobe",
                int'({reg_addr, reg_wdata}), int'({a, d}));
         end
      end
      if (reg_rd) begin
         if (exp_ra.size() == 0) chk(0, "R8/R9 unexpected read", int'(reg_addr), 0);
         else begin
            logic [6:0] a;
            a = exp_ra.pop_front();
            chk(reg_addr == a, "R9 read strobe addr", int'(reg_addr), int'(a));
         end
      end
      if (sda_oe && !oe_prev) chk(!scl_m, "R10 pull while SCL low", int'(scl_m), 0);
      oe_prev = sda_oe;
   end

   task automatic hwait(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hwait(H); scl_m = 1'b1; hwait(H);
      sda_m = 1'b0; hwait(H); scl_m = 1'b0; hwait(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hwait(H); scl_m = 1'b1; hwait(H); sda_m = 1'b1; hwait(H);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; hwait(H); scl_m = 1'b1; hwait(H); scl_m = 1'b0; hwait(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; hwait(H); scl_m = 1'b1; hwait(H/2);
      ack = !sda_line;
      hwait(H/2); scl_m = 1'b0; hwait(2);
   endtask

   task automatic recv_byte(input bit more, output logic [7:0] v);
      v = '0;
      for (int i = 0; i < 8; i++) begin
         sda_m = 1'b1; hwait(H); scl_m = 1'b1; hwait(H/2);
         v = {v[6:0], sda_line};
         hwait(H/2); scl_m = 1'b0; hwait(2);
      end
      send_bit(more ? 1'b0 : 1'b1);
   endtask

   task automatic wr_txn(input logic [6:0] dev, input logic [7:0] sub, input int n, input bit exp_ack);
      bit ack;
      bus_start();
      send_byte({dev, 1'b0}, ack);
      chk(ack == exp_ack, "R1 address acknowledge", int'(ack), int'(exp_ack));
      if (exp_ack) begin
         for (int i = 0; i < n; i++) begin
            logic [6:0] a;
            a = sub[6:0] + (inc ? 7'(i) : 7'd0);
            exp_wa.push_back(a); exp_wd.push_back(wbuf[i]); shadow[a] = wbuf[i];
         end
      end
      send_byte(sub, ack);
      chk(ack == exp_ack, "R4 sub-address acknowledge", int'(ack), int'(exp_ack));
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ack);
         chk(ack == exp_ack, "R5 data acknowledge", int'(ack), int'(exp_ack));
      end
      bus_stop();
      chk(exp_wa.size() == 0, "R5 all writes seen", exp_wa.size(), 0);
   endtask

   task automatic rd_txn(input logic [6:0] dev, input logic [7:0] sub, input int n);
      bit ack;
      logic [7:0] v;
      bus_start();
      send_byte({dev, 1'b0}, ack);
      send_byte(sub, ack);
      for (int i = 0; i < n; i++) exp_ra.push_back(sub[6:0] + (inc ? 7'(i) : 7'd0));
      bus_start();
      send_byte({dev, 1'b1}, ack);
      chk(ack, "R7 read address acknowledge", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
         logic [6:0] a;
         a = sub[6:0] + (inc ? 7'(i) : 7'd0);
         recv_byte(i < n - 1, v);
         chk(v == shadow[a], "R7/R3 read data", int'(v), int'(shadow[a]));
      end
      bus_stop();
      chk(exp_ra.size() == 0, "R8 read ended after NACK", exp_ra.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      bit ack;
      for (int i = 0; i < 128; i++) begin
         rf[i] = 8'(i * 7 + 3);
         shadow[i] = 8'(i * 7 + 3);
      end
      hwait(5);
      chk(sda_oe == 0 && reg_we == 0 && reg_rd == 0, "R11 reset state",
          int'({sda_oe, reg_we, reg_rd}), 0);
      rst_n = 1'b1;
      hwait(5);

      // R5/R6: burst write with increment
      inc = 1;
      wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
      wr_txn(7'h1D, 8'h10, 3, 1);
      chk(rf[16] == 8'hA5 && rf[18] == 8'hF0, "R6 incremented writes", int'(rf[18]), 8'hF0);

      // R6: fixed pointer
      inc = 0;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      wr_txn(7'h1D, 8'h20, 2, 1);
      chk(rf[32] == 8'h22 && rf[33] == shadow[33], "R6 fixed pointer", int'(rf[32]), 8'h22);

      // R6: wrap 7Fh -> 00h
      inc = 1;
      wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
      wr_txn(7'h1D, 8'h7F, 2, 1);
      chk(rf[0] == 8'h6B, "R6 pointer wrap", int'(rf[0]), 8'h6B);

      // R4: bit 7 of sub-address ignored
      wbuf[0] = 8'h99;
      wr_txn(7'h1D, 8'h85, 1, 1);
      chk(rf[5] == 8'h99, "R4 sub-address bit 7 ignored", int'(rf[5]), 8'h99);

      // R1: wrong address with strap high, no ack and no write
      wbuf[0] = 8'h77;
      wr_txn(7'h1E, 8'h40, 1, 0);
      chk(rf[64] == shadow[64], "R1 mismatched address no write", int'(rf[64]), int'(shadow[64]));

      // R1: strap low swaps the accepted address
      strap = 0;
      wbuf[0] = 8'h42;
      wr_txn(7'h1E, 8'h41, 1, 1);
      wr_txn(7'h1D, 8'h42, 1, 0);
      chk(rf[65] == 8'h42 && rf[66] == shadow[66], "R1 strap low", int'(rf[65]), 8'h42);
      strap = 1;

      // R2: STOP after four data bits, no write
      bus_start();
      send_byte({7'h1D, 1'b0}, ack);
      send_byte(8'h30, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_stop();
      chk(rf[48] == shadow[48], "R2 partial byte not written", int'(rf[48]), int'(shadow[48]));

      // R2: repeated START inside sub-address restarts reception
      bus_start();
      send_byte({7'h1D, 1'b0}, ack);
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      wbuf[0] = 8'hC3;
      wr_txn(7'h1D, 8'h31, 1, 1);
      chk(rf[49] == 8'hC3, "R2 restart mid-byte", int'(rf[49]), 8'hC3);

      // R7/R8/R9: reads
      inc = 1;
      rd_txn(7'h1D, 8'h10, 3);
      rd_txn(7'h1D, 8'h7F, 2);
      inc = 0;
      rd_txn(7'h1D, 8'h20, 2);
      inc = 1;
      rd_txn(7'h1D, 8'h05, 1);

      hwait(10);
      chk(sda_oe == 0, "R8 SDA released at end", int'(sda_oe), 0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule